// File: doc/BRIEF.md
# Read-Sequence Store/Recall Controller

This controller sits beside an SRAM-style memory port and watches the addresses of its read cycles. A fixed run of five read addresses, followed by a sixth read at one of two command addresses, asks for one of two transfers. A STORE copies the SRAM into nonvolatile cells. A RECALL clears the SRAM and then reloads it from the nonvolatile cells. No command register is involved. When a valid run completes, the block raises `busy` for a parameterised number of clock cycles. While `busy` is high, the memory port is shut off. The block also drives one-cycle strobes that tell a nonvolatile-array model what to do and when it is finished.

The controller also decides when a write may reach the array. Writes are refused while busy and while the supply-low flag is high. After reset and after every STORE or RECALL, a write that was already being held (enable and write-enable both low) stays refused until a fresh falling edge appears on either of those two strobes.

Top module: `addrseq_nvctl`

## Requirements
- R1: During and right after synchronous reset, `busy`, `wr_allow`, `store_start`, `recall_clear`, `recall_load` and `op_done` are all 0.
- R2: Reads at 0x4E38, 0xB1C7, 0x83E0, 0x7C1F, 0x703F in that order, then a read at 0x8FC0, start a STORE. `busy` and a one-cycle `store_start` appear in the cycle after the clock edge that samples the sixth read.
- R3: The same five-read prefix followed by a read at 0x4C63 starts a RECALL. `recall_clear` pulses in the first busy cycle, `recall_load` pulses in the second busy cycle, and `store_start` stays 0.
- R4: `busy` stays high for exactly STORE_CYCLES cycles (STORE) or RECALL_CYCLES cycles (RECALL). `op_done` pulses for one cycle in the first cycle after `busy` falls.
- R5: A read event is a cycle with `mem_en_n`=0, `mem_oe_n`=0 and `mem_we_n`=1 whose address differs from the previous cycle, or whose previous cycle was not a read. A held read therefore counts once. Cycles with `mem_oe_n`=1 leave the matcher unchanged. A write cycle (`mem_en_n`=0, `mem_we_n`=0) returns the matcher to idle.
- R6: A read event that does not match the next expected address returns the matcher to idle. If that address equals 0x4E38, the matcher instead takes it as the first step of a new run.
- R7: While `busy` is high, `wr_allow` is 0 and read events are ignored, so a complete run issued during busy starts nothing.
- R8: While `low_volt` is 1, `wr_allow` is 0. A run ending at 0x8FC0 with `low_volt`=1 starts no STORE and leaves the matcher idle.
- R9: If enable and write-enable are both low through reset, or at the end of a STORE or RECALL, `wr_allow` stays 0 until one of them leaves the low level and falls again.
- R10: With no lock, not busy and `low_volt`=0, `wr_allow` is 1 in the cycle after an edge that samples `mem_en_n`=0 and `mem_we_n`=0, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_en_n | input | 1 | Memory enable, active low |
| mem_oe_n | input | 1 | Output enable, active low |
| mem_we_n | input | 1 | Write enable, active low |
| mem_addr | input | 16 | Access address |
| low_volt | input | 1 | Supply-low flag |
| busy | output | 1 | Transfer in progress; memory port disabled |
| wr_allow | output | 1 | Write may reach the array |
| store_start | output | 1 | One-cycle STORE start strobe |
| recall_clear | output | 1 | One-cycle RECALL clear-phase strobe |
| recall_load | output | 1 | One-cycle RECALL load-phase strobe |
| op_done | output | 1 | One-cycle end-of-transfer strobe |

## Verification
The hardest state to reach from the ports is a write lock with enable and write-enable held low across an edge that arms the lock. The stimulus reaches it in two ways. First, it holds a write through reset. Second, it keeps driving write cycles all through a RECALL and beyond its end, and only then releases and re-lowers write-enable. Mismatch recovery is swept at every step of the run, once with a foreign address and once with the first sequence address. Each variant is then finished with the rest of the run, which shows whether the matcher went idle or restarted.

// File: rtl/addrseq_pkg.sv
package addrseq_pkg;
  localparam int ADDR_W     = 16;
  localparam int PREFIX_LEN = 5;
  localparam int STEP_W     = $clog2(PREFIX_LEN + 1);

  typedef logic [ADDR_W-1:0] addr_t;

  // ordered run of addresses; the order is what the matcher decodes
  localparam addr_t PREFIX [PREFIX_LEN] = '{16'h4E38, 16'hB1C7, 16'h83E0, 16'h7C1F, 16'h703F};
  localparam addr_t STORE_KEY  = 16'h8FC0;
  localparam addr_t RECALL_KEY = 16'h4C63;

  typedef enum logic [1:0] {OP_NONE, OP_STORE, OP_RECALL} op_e;
endpackage

// File: rtl/addrseq_bus_mon.sv
module addrseq_bus_mon
  import addrseq_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  en_n,
  input  logic  oe_n,
  input  logic  we_n,
  input  addr_t addr,
  output logic  rd_evt,
  output logic  wr_cyc
);
  logic  rd_now;
  logic  rd_prev;
  addr_t addr_prev;

  assign rd_now = !en_n && !oe_n && we_n;
  assign wr_cyc = !en_n && !we_n;
  // a held read at the same address is one access
  assign rd_evt = rd_now && (!rd_prev || (addr != addr_prev));

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_prev   <= 1'b0;
      addr_prev <= '0;
    end else begin
      rd_prev   <= rd_now;
      addr_prev <= addr;
    end
  end
endmodule

// File: rtl/addrseq_matcher.sv
module addrseq_matcher
  import addrseq_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  rd_evt,
  input  logic  wr_cyc,
  input  addr_t addr,
  input  logic  busy,
  input  logic  low_volt,
  output logic  go_store,
  output logic  go_recall
);
  logic [STEP_W-1:0]   step_q, step_d;
  logic [PREFIX_LEN:0] hit;
  logic                at_final;

  genvar gi;
  generate
    for (gi = 0; gi < PREFIX_LEN; gi++) begin : g_cmp
      assign hit[gi] = (addr == PREFIX[gi]);
    end
  endgenerate
  assign hit[PREFIX_LEN] = 1'b0;

  assign at_final = (step_q == STEP_W'(PREFIX_LEN));

  always_comb begin
    step_d    = step_q;
    go_store  = 1'b0;
    go_recall = 1'b0;
    if (busy || wr_cyc) begin
      step_d = '0;
    end else if (rd_evt) begin
      if (at_final && addr == STORE_KEY && !low_volt) begin
        go_store = 1'b1;
        step_d   = '0;
      end else if (at_final && addr == RECALL_KEY) begin
        go_recall = 1'b1;
        step_d    = '0;
      end else if (!at_final && hit[step_q]) begin
        step_d = step_q + STEP_W'(1);
      end else begin
        step_d = hit[0] ? STEP_W'(1) : '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) step_q <= '0;
    else     step_q <= step_d;
  end
endmodule

// File: rtl/addrseq_busy_timer.sv
module addrseq_busy_timer
  import addrseq_pkg::*;
#(
  parameter int STORE_CYCLES  = 20,
  parameter int RECALL_CYCLES = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic go_store,
  input  logic go_recall,
  output logic busy,
  output logic store_start,
  output logic recall_clear,
  output logic recall_load,
  output logic op_done
);
  localparam int MAX_CYC = (STORE_CYCLES > RECALL_CYCLES) ? STORE_CYCLES : RECALL_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] cnt_q;
  op_e              kind_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy         <= 1'b0;
      cnt_q        <= '0;
      kind_q       <= OP_NONE;
      store_start  <= 1'b0;
      recall_clear <= 1'b0;
      recall_load  <= 1'b0;
      op_done      <= 1'b0;
    end else begin
      store_start  <= 1'b0;
      recall_clear <= 1'b0;
      recall_load  <= 1'b0;
      op_done      <= 1'b0;
      if (!busy) begin
        if (go_store) begin
          busy        <= 1'b1;
          cnt_q       <= CNT_W'(STORE_CYCLES - 1);
          kind_q      <= OP_STORE;
          store_start <= 1'b1;
        end else if (go_recall) begin
          busy         <= 1'b1;
          cnt_q        <= CNT_W'(RECALL_CYCLES - 1);
          kind_q       <= OP_RECALL;
          recall_clear <= 1'b1;
        end
      end else begin
        if (cnt_q == '0) begin
          busy    <= 1'b0;
          op_done <= 1'b1;
          kind_q  <= OP_NONE;
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
        // load phase follows the clear phase by one cycle
        if (kind_q == OP_RECALL && cnt_q == CNT_W'(RECALL_CYCLES - 1))
          recall_load <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/addrseq_write_guard.sv
module addrseq_write_guard (
  input  logic clk,
  input  logic rst,
  input  logic en_n,
  input  logic we_n,
  input  logic low_volt,
  input  logic busy,
  input  logic go,
  output logic wr_allow
);
  logic en_prev, we_prev, lock_q, lock_d;
  logic both_low, fall;

  assign both_low = !en_n && !we_n;
  assign fall     = (en_prev && !en_n) || (we_prev && !we_n);
  assign lock_d   = busy ? 1'b1 : (lock_q && both_low && !fall);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_prev  <= en_n;
      we_prev  <= we_n;
      lock_q   <= 1'b1;
      wr_allow <= 1'b0;
    end else begin
      en_prev  <= en_n;
      we_prev  <= we_n;
      lock_q   <= lock_d;
      wr_allow <= !busy && !go && !low_volt && both_low && !lock_d;
    end
  end
endmodule

// File: rtl/addrseq_nvctl.sv
module addrseq_nvctl
  import addrseq_pkg::*;
#(
  parameter int STORE_CYCLES  = 20,
  parameter int RECALL_CYCLES = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mem_en_n,
  input  logic              mem_oe_n,
  input  logic              mem_we_n,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic              low_volt,
  output logic              busy,
  output logic              wr_allow,
  output logic              store_start,
  output logic              recall_clear,
  output logic              recall_load,
  output logic              op_done
);
  logic rd_evt, wr_cyc, go_store, go_recall;

  addrseq_bus_mon mon_i (
    .clk(clk), .rst(rst), .en_n(mem_en_n), .oe_n(mem_oe_n), .we_n(mem_we_n),
    .addr(mem_addr), .rd_evt(rd_evt), .wr_cyc(wr_cyc)
  );

  addrseq_matcher match_i (
    .clk(clk), .rst(rst), .rd_evt(rd_evt), .wr_cyc(wr_cyc), .addr(mem_addr),
    .busy(busy), .low_volt(low_volt), .go_store(go_store), .go_recall(go_recall)
  );

  addrseq_busy_timer #(.STORE_CYCLES(STORE_CYCLES), .RECALL_CYCLES(RECALL_CYCLES)) timer_i (
    .clk(clk), .rst(rst), .go_store(go_store), .go_recall(go_recall), .busy(busy),
    .store_start(store_start), .recall_clear(recall_clear), .recall_load(recall_load),
    .op_done(op_done)
  );

  addrseq_write_guard guard_i (
    .clk(clk), .rst(rst), .en_n(mem_en_n), .we_n(mem_we_n), .low_volt(low_volt),
    .busy(busy), .go(go_store || go_recall), .wr_allow(wr_allow)
  );
endmodule

// File: rtl/addrseq_nvctl_chk.sv
module addrseq_nvctl_chk #(
  parameter int STORE_CYCLES  = 20,
  parameter int RECALL_CYCLES = 12
) (
  input logic clk,
  input logic rst,
  input logic low_volt,
  input logic busy,
  input logic wr_allow,
  input logic store_start,
  input logic recall_clear,
  input logic recall_load,
  input logic op_done
);
  logic [15:0] run_q;
  logic        was_store_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q       <= '0;
      was_store_q <= 1'b0;
    end else if (store_start || recall_clear) begin
      run_q       <= 16'd1;
      was_store_q <= store_start;
    end else if (busy) begin
      run_q <= run_q + 16'd1;
    end
  end

  p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
    store_start |-> busy);
  p_start_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    store_start |=> !store_start);
  p_clear_then_load_r3: assert property (@(posedge clk) disable iff (rst)
    recall_clear |=> recall_load);
  p_strobes_excl_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({store_start, recall_clear, recall_load, op_done}));
  p_done_after_busy_r4: assert property (@(posedge clk) disable iff (rst)
    op_done |-> ($past(busy) && !busy));
  p_busy_len_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (run_q == (was_store_q ? 16'(STORE_CYCLES) : 16'(RECALL_CYCLES))));
  p_no_wr_busy_r7: assert property (@(posedge clk) disable iff (rst)
    busy |-> !wr_allow);
  p_no_restart_r7: assert property (@(posedge clk) disable iff (rst)
    $past(busy) |-> !(store_start || recall_clear));
  p_lv_no_wr_r8: assert property (@(posedge clk) disable iff (rst)
    $past(low_volt) |-> !wr_allow);
endmodule

bind addrseq_nvctl addrseq_nvctl_chk #(.STORE_CYCLES(STORE_CYCLES), .RECALL_CYCLES(RECALL_CYCLES)) chk_i (
  .clk(clk), .rst(rst), .low_volt(low_volt), .busy(busy), .wr_allow(wr_allow),
  .store_start(store_start), .recall_clear(recall_clear), .recall_load(recall_load),
  .op_done(op_done)
);

// File: tb/addrseq_nvctl_tb_top.sv
`timescale 1ns/1ps
module addrseq_nvctl_tb_top;
  localparam int ST_CYC = 20;
  localparam int RC_CYC = 12;
  localparam logic [15:0] K_ST = 16'h8FC0;
  localparam logic [15:0] K_RC = 16'h4C63;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en_n, oe_n, we_n, low_volt;
  logic [15:0] addr;
  logic        busy, wr_allow, store_start, recall_clear, recall_load, op_done;
  int          n_chk = 0;
  int          n_fail = 0;
  logic [15:0] seq_tab [5] = '{16'h4E38, 16'hB1C7, 16'h83E0, 16'h7C1F, 16'h703F};

  always #2.5 clk = ~clk;

  addrseq_nvctl #(.STORE_CYCLES(ST_CYC), .RECALL_CYCLES(RC_CYC)) dut_i (
    .clk(clk), .rst(rst), .mem_en_n(en_n), .mem_oe_n(oe_n), .mem_we_n(we_n),
    .mem_addr(addr), .low_volt(low_volt), .busy(busy), .wr_allow(wr_allow),
    .store_start(store_start), .recall_clear(recall_clear), .recall_load(recall_load),
    .op_done(op_done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic rd(input logic [15:0] a);
    en_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
    @(negedge clk);
  endtask

  task automatic wr1(input logic [15:0] a);
    en_n = 1'b0; oe_n = 1'b1; we_n = 1'b0; addr = a;
    @(negedge clk);
  endtask

  task automatic idle1();
    en_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_prefix(input int from);
    for (int i = from; i < 5; i++) rd(seq_tab[i]);
  endtask

  // called right after the sampled read at the STORE key
  task automatic expect_store(input string req);
    int n;
    chk({req, " R2 busy"}, busy, 1);
    chk({req, " R2 store_start"}, store_start, 1);
    n = 1;
    for (int k = 0; k < 100; k++) begin
      idle1();
      if (busy) begin
        n++;
        chk("R2 store_start single", store_start, 0);
      end else break;
    end
    chk({req, " R4 store length"}, n, ST_CYC);
    chk({req, " R4 op_done"}, op_done, 1);
    idle1();
    chk("R4 op_done single", op_done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int n;
    // write held through reset
    en_n = 1'b0; oe_n = 1'b1; we_n = 1'b0; addr = 16'h0; low_volt = 1'b0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 wr_allow", wr_allow, 0);
    chk("R1 strobes", {store_start, recall_clear, recall_load, op_done}, 0);
    rst = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R9 locked after reset", wr_allow, 0);
      chk("R1 busy after reset", busy, 0);
    end
    we_n = 1'b1; @(negedge clk);
    we_n = 1'b0; @(negedge clk);
    chk("R9 fresh edge unlocks", wr_allow, 1);
    @(negedge clk);
    chk("R10 held write allowed", wr_allow, 1);
    low_volt = 1'b1; @(negedge clk);
    chk("R8 low volt blocks write", wr_allow, 0);
    low_volt = 1'b0; @(negedge clk);
    chk("R10 write after low volt", wr_allow, 1);
    idle1();
    chk("R10 no write no allow", wr_allow, 0);

    // basic STORE
    run_prefix(0); rd(K_ST);
    expect_store("basic");

    // basic RECALL
    run_prefix(0); rd(K_RC);
    chk("R3 busy", busy, 1);
    chk("R3 recall_clear", recall_clear, 1);
    chk("R3 no load yet", recall_load, 0);
    chk("R3 no store_start", store_start, 0);
    idle1();
    chk("R3 recall_load", recall_load, 1);
    chk("R3 clear single", recall_clear, 0);
    n = 2;
    for (int k = 0; k < 100; k++) begin
      idle1();
      if (busy) n++; else break;
    end
    chk("R4 recall length", n, RC_CYC);
    chk("R4 recall op_done", op_done, 1);
    idle1();

    // R5 output-enable high cycle is ignored
    run_prefix(0);
    en_n = 1'b0; oe_n = 1'b1; we_n = 1'b1; addr = 16'h0000; @(negedge clk);
    rd(seq_tab[0]); rd(seq_tab[1]);
    chk("R5 oe-high no start", busy, 0);
    idle1();
    rd(seq_tab[0]); rd(seq_tab[1]); rd(seq_tab[2]);
    en_n = 1'b0; oe_n = 1'b1; we_n = 1'b1; addr = 16'h1111; @(negedge clk);
    rd(seq_tab[3]); rd(seq_tab[4]); rd(K_ST);
    expect_store("R5 oe-high ignored");
    // R5 write cycle returns to idle
    rd(seq_tab[0]); rd(seq_tab[1]); rd(seq_tab[2]);
    wr1(seq_tab[3]);
    rd(seq_tab[3]); rd(seq_tab[4]); rd(K_ST);
    chk("R5 write resets matcher", busy, 0);
    idle1();
    // R5 held read counts once
    rd(seq_tab[0]); rd(seq_tab[1]); rd(seq_tab[1]);
    rd(seq_tab[2]); rd(seq_tab[3]); rd(seq_tab[4]); rd(K_ST);
    expect_store("R5 held read once");
    // R5 separated repeat counts twice
    rd(seq_tab[0]); rd(seq_tab[1]); idle1(); rd(seq_tab[1]);
    rd(seq_tab[2]); rd(seq_tab[3]); rd(seq_tab[4]); rd(K_ST);
    chk("R5 repeat read mismatches", busy, 0);
    idle1();

    // R6 sweep: foreign address at every step
    for (int p = 1; p <= 5; p++) begin
      for (int i = 0; i < p; i++) rd(seq_tab[i]);
      rd(16'h1234);
      for (int i = p; i < 5; i++) rd(seq_tab[i]);
      rd(K_ST);
      chk($sformatf("R6 foreign at step %0d no start", p), busy, 0);
      idle1();
    end
    // R6 sweep: first address at every step restarts
    for (int p = 1; p <= 5; p++) begin
      for (int i = 0; i < p; i++) rd(seq_tab[i]);
      idle1();
      rd(seq_tab[0]);
      run_prefix(1); rd(K_ST);
      expect_store($sformatf("R6 restart at step %0d", p));
    end

    // R7 run issued during busy is ignored
    run_prefix(0); rd(K_ST);
    chk("R7 busy", busy, 1);
    n = 1;
    for (int i = 0; i < 5; i++) begin
      rd(seq_tab[i]); n++;
      chk("R7 busy holds", busy, 1);
    end
    rd(K_ST); n++;
    chk("R7 no restart strobe", store_start, 0);
    for (int k = 0; k < 100; k++) begin
      idle1();
      if (busy) begin
        n++;
        chk("R7 no write while busy", wr_allow, 0);
      end else break;
    end
    chk("R7 length unchanged", n, ST_CYC);
    for (int k = 0; k < 3; k++) begin
      idle1();
      chk("R7 no late start", busy, 0);
    end

    // R8 low voltage blocks STORE and leaves matcher idle
    low_volt = 1'b1;
    run_prefix(0); rd(K_ST);
    chk("R8 no store under low volt", busy, 0);
    low_volt = 1'b0;
    run_prefix(1); rd(K_ST);
    chk("R8 matcher idle after refusal", busy, 0);
    idle1();

    // R9 write held across end of RECALL
    run_prefix(0); rd(K_RC);
    chk("R9 recall started", busy, 1);
    for (int k = 0; k < 100; k++) begin
      wr1(16'h0042);
      if (busy) chk("R7 write blocked in recall", wr_allow, 0);
      else break;
    end
    for (int k = 0; k < 3; k++) begin
      wr1(16'h0042);
      chk("R9 locked after recall", wr_allow, 0);
    end
    en_n = 1'b0; oe_n = 1'b1; we_n = 1'b1; @(negedge clk);
    wr1(16'h0042);
    chk("R9 unlock by new edge", wr_allow, 1);
    idle1();

    summary();
    $finish;
  end
endmodule